// File: doc/BRIEF.md
# I2C Eight-Bit Port Expander Target

This block is an I2C target that owns an eight-bit general-purpose port. A bus master reaches four internal byte registers through it: the sampled pin levels (optionally inverted per bit), an output latch, a per-bit inversion mask and a per-bit direction mask. Pins whose direction bit is 1 are inputs with their driver off; pins whose direction bit is 0 drive the output latch value.

The target answers to a seven-bit address whose upper four bits are fixed (binary 0111 by default) and whose lower three bits come from strap inputs, so eight of these blocks can share one bus at addresses 0x38 to 0x3F. A write transfer carries a selector byte first, which picks one of the four registers; any further bytes in that transfer are written to the selected register. A read transfer never carries a selector: it returns the register chosen by the most recent selector byte, for as long as the master keeps acknowledging. The selector persists across STOP and repeated START conditions.

An active-low interrupt flags any input pin whose level differs from the level captured at the last read of the pin register. SCL and SDA are sampled with the block clock, which must run well above the bus bit rate. The block never stretches SCL.

Top module: `i2cx_port_expander`

## Requirements
- R1: The target acknowledges (drives SDA low through the ninth SCL pulse) an address byte whose upper seven bits equal 0111 followed by strap bits [2:0]; any other address gets no acknowledge and the target leaves SDA released until the next START.
- R2: Bit 0 of the address byte picks the direction (1 = read, 0 = write); in a read the target shifts out the selected register MSB first and sends that same register again after every master acknowledge.
- R3: In a write transfer the first byte after the address is a selector; its bits [1:0] choose the register (0 = pin register, 1 = output latch, 2 = inversion mask, 3 = direction mask) and the target acknowledges it.
- R4: A read transfer never changes the selector; every later read returns the last selected register until a new selector byte is written.
- R5: Each data byte that follows the selector in a write is acknowledged and overwrites the selected register; the selector does not advance.
- R6: Data bytes written while the selector is 0 are acknowledged but change no register.
- R7: Reading selector 0 returns the synchronized pin levels XOR the inversion mask.
- R8: For each bit, port_oe is 1 when the direction bit is 0 and 0 when it is 1; port_o always shows the output latch.
- R9: After reset the output latch is 0xFF, the inversion mask 0x00, the direction mask 0xFF (all inputs, so port_oe = 0x00), the selector 0, SDA is released and int_n is high.
- R10: int_n goes low when any pin with direction bit 1 differs from the level captured at the last read of selector 0; pins with direction bit 0 never assert it.
- R11: int_n returns high when the differing pins return to their captured level, or when selector 0 is read (which captures the current levels).
- R12: A master NACK after a read byte ends the transfer: the target releases SDA and drives nothing more until the next START.
- R13: A repeated START restarts address matching and keeps the selector.
- R14: A STOP (SDA rising while SCL is high) returns the target to idle with SDA released; SCL pulses after a STOP without a START are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen on the bus |
| scl_o | output | 1 | SCL drive value (always 0) |
| scl_oe | output | 1 | SCL pull-down enable (always 0) |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_o | output | 1 | SDA drive value (always 0) |
| sda_oe | output | 1 | SDA pull-down enable |
| addr_strap | input | 3 | Low three bits of the target address |
| port_i | input | 8 | Pin levels of the port |
| port_o | output | 8 | Output latch driven to the pins |
| port_oe | output | 8 | Per-pin driver enable |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench aims at the selector's lifetime: a design that reloaded it from the first byte of a read, or cleared it on STOP or repeated START, would return the wrong register in bare reads and after a restart. It writes to the pin register to catch a design that lets such bytes fall through to another register, and sends several data bytes in one write to catch a selector that auto-increments. It checks that a NACKed read leaves SDA released under further SCL pulses, and that bits clocked after a STOP with no START draw no acknowledge. The interrupt is driven both ways, by a pin returning and by a pin-register read, and with output-configured pins that must stay silent.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_CMD,
        ST_ACK_W,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } fsm_state_e;

    typedef enum logic [1:0] {
        PTR_PINS   = 2'd0,
        PTR_LATCH  = 2'd1,
        PTR_INVERT = 2'd2,
        PTR_DIR    = 2'd3
    } reg_sel_e;

    localparam logic [BYTE_W-1:0] RST_LATCH  = 8'hFF;
    localparam logic [BYTE_W-1:0] RST_INVERT = 8'h00;
    localparam logic [BYTE_W-1:0] RST_DIR    = 8'hFF;

endpackage

// File: rtl/i2cx_line_sync.sv
module i2cx_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_prev;
        logic                   sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_pipe = {sync_q.scl_pipe[SYNC_STAGES-2:0], scl_i};
        sync_d.sda_pipe = {sync_q.sda_pipe[SYNC_STAGES-2:0], sda_i};
        sync_d.scl_prev = sync_q.scl_pipe[LAST];
        sync_d.sda_prev = sync_q.sda_pipe[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    logic scl_now, sda_now;
    assign scl_now   = sync_q.scl_pipe[LAST];
    assign sda_now   = sync_q.sda_pipe[LAST];
    assign sda_s     = sda_now;
    assign scl_rise  = scl_now & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_now & sync_q.scl_prev;
    assign start_det = scl_now & sync_q.scl_prev & sync_q.sda_prev & ~sda_now;
    assign stop_det  = scl_now & sync_q.scl_prev & ~sync_q.sda_prev & sda_now;

endmodule

// File: rtl/i2cx_target_fsm.sv
module i2cx_target_fsm
    import i2cx_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b0111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr_strap,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              cmd_en,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_strobe
);

    localparam logic [3:0] BITS_IN = 4'd8;
    localparam logic [3:0] LAST_TX = 4'd7;

    typedef struct packed {
        fsm_state_e        st;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic              oe;
        logic              rw;
        logic              mack;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d     = fsm_q;
        cmd_en    = 1'b0;
        wr_en     = 1'b0;
        rd_strobe = 1'b0;
        if (stop_det) begin
            fsm_d.st  = ST_IDLE;
            fsm_d.oe  = 1'b0;
            fsm_d.cnt = '0;
        end else if (start_det) begin
            fsm_d.st  = ST_ADDR;
            fsm_d.oe  = 1'b0;
            fsm_d.cnt = '0;
        end else begin
            case (fsm_q.st)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise && fsm_q.cnt < BITS_IN) begin
                        fsm_d.rx  = {fsm_q.rx[BYTE_W-2:0], sda_s};
                        fsm_d.cnt = fsm_q.cnt + 4'd1;
                    end else if (scl_fall && fsm_q.cnt == BITS_IN) begin
                        fsm_d.cnt = '0;
                        if (fsm_q.st == ST_ADDR) begin
                            if (fsm_q.rx[BYTE_W-1:1] == {ADDR_HI, addr_strap}) begin
                                fsm_d.oe = 1'b1;
                                fsm_d.rw = fsm_q.rx[0];
                                fsm_d.st = ST_ACK_A;
                            end else begin
                                fsm_d.st = ST_IGNORE;
                            end
                        end else if (fsm_q.st == ST_CMD) begin
                            cmd_en   = 1'b1;
                            fsm_d.oe = 1'b1;
                            fsm_d.st = ST_ACK_W;
                        end else begin
                            wr_en    = 1'b1;
                            fsm_d.oe = 1'b1;
                            fsm_d.st = ST_ACK_W;
                        end
                    end
                end
                ST_ACK_A: begin
                    if (scl_fall) begin
                        fsm_d.cnt = '0;
                        if (fsm_q.rw) begin
                            rd_strobe = 1'b1;
                            fsm_d.tx  = rd_data;
                            fsm_d.oe  = ~rd_data[BYTE_W-1];
                            fsm_d.st  = ST_RDATA;
                        end else begin
                            fsm_d.oe = 1'b0;
                            fsm_d.st = ST_CMD;
                        end
                    end
                end
                ST_ACK_W: begin
                    if (scl_fall) begin
                        fsm_d.oe  = 1'b0;
                        fsm_d.cnt = '0;
                        fsm_d.st  = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (fsm_q.cnt == LAST_TX) begin
                            fsm_d.oe  = 1'b0;
                            fsm_d.cnt = '0;
                            fsm_d.st  = ST_RACK;
                        end else begin
                            fsm_d.cnt = fsm_q.cnt + 4'd1;
                            fsm_d.tx  = {fsm_q.tx[BYTE_W-2:0], 1'b0};
                            fsm_d.oe  = ~fsm_q.tx[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        fsm_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (fsm_q.mack) begin
                            rd_strobe = 1'b1;
                            fsm_d.tx  = rd_data;
                            fsm_d.oe  = ~rd_data[BYTE_W-1];
                            fsm_d.cnt = '0;
                            fsm_d.st  = ST_RDATA;
                        end else begin
                            fsm_d.st = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q    <= '0;
            fsm_q.st <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_oe  = fsm_q.oe;
    assign wr_data = fsm_q.rx;

    // Idle or unaddressed: the target must leave SDA alone.
    assert_quiet_unaddressed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_IDLE || fsm_q.st == ST_IGNORE) |-> !fsm_q.oe);

    // Every written byte is acknowledged for the whole ninth clock.
    assert_write_ack_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_ACK_W) |-> fsm_q.oe);

    // A STOP always lands in idle with SDA released.
    assert_stop_to_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (fsm_q.st == ST_IDLE && !fsm_q.oe));

endmodule

// File: rtl/i2cx_port_regs.sv
module i2cx_port_regs
    import i2cx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] port_i,
    input  logic              cmd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_strobe,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] port_o,
    output logic [BYTE_W-1:0] port_oe,
    output logic              int_n
);

    localparam logic [1:0] WARM_DONE = 2'd3;

    typedef struct packed {
        reg_sel_e          ptr;
        logic [BYTE_W-1:0] latch;
        logic [BYTE_W-1:0] invert;
        logic [BYTE_W-1:0] dir;
        logic [BYTE_W-1:0] snap;
        logic [BYTE_W-1:0] pin_a;
        logic [BYTE_W-1:0] pin_b;
        logic [1:0]        warm;
        logic              irq;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d       = regs_q;
        regs_d.pin_a = port_i;
        regs_d.pin_b = regs_q.pin_a;
        if (regs_q.warm != WARM_DONE) begin
            regs_d.warm = regs_q.warm + 2'd1;
            regs_d.snap = regs_q.pin_b;
        end
        if (cmd_en) regs_d.ptr = reg_sel_e'(wr_data[1:0]);
        if (wr_en) begin
            case (regs_q.ptr)
                PTR_LATCH:  regs_d.latch  = wr_data;
                PTR_INVERT: regs_d.invert = wr_data;
                PTR_DIR:    regs_d.dir    = wr_data;
                default: ;
            endcase
        end
        if (rd_strobe && regs_q.ptr == PTR_PINS) regs_d.snap = regs_q.pin_b;
        regs_d.irq = (regs_q.warm == WARM_DONE) &&
                     (|((regs_q.pin_b ^ regs_q.snap) & regs_q.dir));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q        <= '0;
            regs_q.ptr    <= PTR_PINS;
            regs_q.latch  <= RST_LATCH;
            regs_q.invert <= RST_INVERT;
            regs_q.dir    <= RST_DIR;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (regs_q.ptr)
            PTR_PINS:   rd_data = regs_q.pin_b ^ regs_q.invert;
            PTR_LATCH:  rd_data = regs_q.latch;
            PTR_INVERT: rd_data = regs_q.invert;
            default:    rd_data = regs_q.dir;
        endcase
    end

    assign port_o  = regs_q.latch;
    assign port_oe = ~regs_q.dir;
    assign int_n   = ~regs_q.irq;

    // Bytes aimed at the pin register leave every writable register alone.
    assert_pin_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && regs_q.ptr == PTR_PINS) |=>
        ($stable(regs_q.latch) && $stable(regs_q.invert) && $stable(regs_q.dir)));

    // With every pin driven, no pin can raise the interrupt.
    assert_outputs_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.dir == '0) |=> !regs_q.irq);

endmodule

// File: rtl/i2cx_port_expander.sv
module i2cx_port_expander
    import i2cx_pkg::*;
#(
    parameter logic [3:0] ADDR_HI     = 4'b0111,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    output logic              scl_o,
    output logic              scl_oe,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe,
    input  logic [2:0]        addr_strap,
    input  logic [BYTE_W-1:0] port_i,
    output logic [BYTE_W-1:0] port_o,
    output logic [BYTE_W-1:0] port_oe,
    output logic              int_n
);

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              cmd_en, wr_en, rd_strobe;
    logic [BYTE_W-1:0] wr_data, rd_data;

    i2cx_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cx_target_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_strap (addr_strap),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe),
        .cmd_en     (cmd_en),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_strobe  (rd_strobe)
    );

    i2cx_port_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_i    (port_i),
        .cmd_en    (cmd_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_strobe (rd_strobe),
        .rd_data   (rd_data),
        .port_o    (port_o),
        .port_oe   (port_oe),
        .int_n     (int_n)
    );

    assign scl_o  = 1'b0;
    assign scl_oe = 1'b0;
    assign sda_o  = 1'b0;

endmodule

// File: tb/sim_i2cx_port_expander.sv
module sim_i2cx_port_expander;

    localparam int         PH    = 12;
    localparam logic [6:0] TADDR = 7'h3D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic [7:0] pins = 8'h00;
    logic       scl_o, scl_oe, sda_o, sda_oe, int_n;
    logic [7:0] port_o, port_oe;
    logic       sda_bus;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;
    logic mon = 1'b0;
    logic oe_seen = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2cx_port_expander u0 (
        .clk(clk), .rst_n(rst_n),
        .scl_i(scl_m), .scl_o(scl_o), .scl_oe(scl_oe),
        .sda_i(sda_bus), .sda_o(sda_o), .sda_oe(sda_oe),
        .addr_strap(strap), .port_i(pins),
        .port_o(port_o), .port_oe(port_oe), .int_n(int_n)
    );

    always @(negedge clk) if (mon && sda_oe) oe_seen = 1'b1;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (PH) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic bus_restart();
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b1; hold();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold();
            scl_m = 1'b1; hold();
            scl_m = 1'b0; hold();
        end
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        ack = ~sda_bus;
        scl_m = 1'b0; hold();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold();
            scl_m = 1'b1; hold();
            b[i] = sda_bus;
            scl_m = 1'b0;
        end
        hold();
        sda_m = ~mack; hold();
        scl_m = 1'b1; hold();
        scl_m = 1'b0; hold();
        sda_m = 1'b1;
    endtask

    task automatic wr_reg(input logic [1:0] p, input logic [7:0] v, output logic ok);
        logic a0, a1, a2;
        bus_start();
        send_byte({TADDR, 1'b0}, a0);
        send_byte({6'd0, p}, a1);
        send_byte(v, a2);
        bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic set_ptr(input logic [1:0] p);
        logic a0, a1;
        bus_start();
        send_byte({TADDR, 1'b0}, a0);
        send_byte({6'd0, p}, a1);
        bus_stop();
    endtask

    task automatic rd_cur(output logic [7:0] v);
        logic a0;
        bus_start();
        send_byte({TADDR, 1'b1}, a0);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R9 port_o after reset", port_o, 8'hFF);
        chk("R9 port_oe after reset", port_oe, 8'h00);
        chk("R9 int_n after reset", {7'd0, int_n}, 8'h01);
        chk("R9 sda released after reset", {7'd0, sda_oe}, 8'h00);
        pins = 8'hA5;
        repeat (10) @(negedge clk);
        rd_cur(v);
        chk("R9 R7 default selector reads pins", v, 8'hA5);
    endtask

    task automatic t_address();
        logic a;
        bus_start(); send_byte({TADDR, 1'b0}, a); bus_stop();
        chk("R1 matching address acked", {7'd0, a}, 8'h01);
        bus_start(); send_byte({7'h3C, 1'b0}, a); bus_stop();
        chk("R1 wrong strap bits not acked", {7'd0, a}, 8'h00);
        bus_start(); send_byte({7'h5D, 1'b0}, a); bus_stop();
        chk("R1 wrong fixed nibble not acked", {7'd0, a}, 8'h00);
    endtask

    task automatic t_write_latch();
        logic ok;
        logic [7:0] v;
        wr_reg(2'd1, 8'h5A, ok);
        chk("R3 selector and data acked", {7'd0, ok}, 8'h01);
        chk("R3 R5 latch on port_o", port_o, 8'h5A);
        rd_cur(v);
        chk("R3 read back latch", v, 8'h5A);
    endtask

    task automatic t_multi_write();
        logic a0, a1, a2, a3;
        logic [7:0] v;
        bus_start();
        send_byte({TADDR, 1'b0}, a0);
        send_byte(8'h01, a1);
        send_byte(8'h11, a2);
        send_byte(8'h22, a3);
        bus_stop();
        chk("R5 both data bytes acked", {7'd0, a2 & a3}, 8'h01);
        chk("R5 last byte in latch", port_o, 8'h22);
        rd_cur(v);
        chk("R5 selector did not advance", v, 8'h22);
    endtask

    task automatic t_direction();
        logic ok;
        wr_reg(2'd3, 8'h0F, ok);
        chk("R8 port_oe inverse of direction", port_oe, 8'hF0);
        chk("R8 port_o still latch", port_o, 8'h22);
        wr_reg(2'd3, 8'hFF, ok);
        chk("R8 all inputs disable drivers", port_oe, 8'h00);
    endtask

    task automatic t_invert();
        logic ok;
        logic [7:0] v;
        pins = 8'h3C;
        wr_reg(2'd2, 8'hFF, ok);
        set_ptr(2'd0);
        rd_cur(v);
        chk("R7 pins xor inversion", v, 8'hC3);
        wr_reg(2'd2, 8'h00, ok);
    endtask

    task automatic t_persist();
        logic ok;
        logic [7:0] v;
        wr_reg(2'd2, 8'h81, ok);
        rd_cur(v);
        chk("R4 first bare read", v, 8'h81);
        rd_cur(v);
        chk("R4 second bare read", v, 8'h81);
        wr_reg(2'd2, 8'h00, ok);
    endtask

    task automatic t_pin_write();
        logic ok;
        logic [7:0] v;
        wr_reg(2'd1, 8'h5A, ok);
        wr_reg(2'd0, 8'h00, ok);
        chk("R6 write to pin register acked", {7'd0, ok}, 8'h01);
        chk("R6 latch unchanged", port_o, 8'h5A);
        chk("R6 direction unchanged", port_oe, 8'h00);
        set_ptr(2'd2);
        rd_cur(v);
        chk("R6 inversion unchanged", v, 8'h00);
    endtask

    task automatic t_multi_read();
        logic a;
        logic [7:0] v1, v2;
        set_ptr(2'd3);
        bus_start();
        send_byte({TADDR, 1'b1}, a);
        recv_byte(1'b1, v1);
        recv_byte(1'b0, v2);
        bus_stop();
        chk("R2 read address acked", {7'd0, a}, 8'h01);
        chk("R2 first read byte", v1, 8'hFF);
        chk("R2 repeated read byte", v2, 8'hFF);
    endtask

    task automatic t_interrupt();
        logic ok;
        logic [7:0] v;
        wr_reg(2'd3, 8'hFF, ok);
        pins = 8'h00;
        set_ptr(2'd0);
        rd_cur(v);
        repeat (10) @(negedge clk);
        chk("R11 int_n high after pin read", {7'd0, int_n}, 8'h01);
        pins = 8'h04;
        repeat (10) @(negedge clk);
        chk("R10 input change asserts int_n", {7'd0, int_n}, 8'h00);
        pins = 8'h00;
        repeat (10) @(negedge clk);
        chk("R11 pin return clears int_n", {7'd0, int_n}, 8'h01);
        pins = 8'h10;
        repeat (10) @(negedge clk);
        chk("R10 second change asserts int_n", {7'd0, int_n}, 8'h00);
        rd_cur(v);
        repeat (10) @(negedge clk);
        chk("R11 pin read clears int_n", {7'd0, int_n}, 8'h01);
        wr_reg(2'd3, 8'hF0, ok);
        pins = 8'h11;
        repeat (10) @(negedge clk);
        chk("R10 driven pin does not interrupt", {7'd0, int_n}, 8'h01);
        pins = 8'h10;
        wr_reg(2'd3, 8'hFF, ok);
    endtask

    task automatic t_nack();
        logic a;
        logic [7:0] v;
        set_ptr(2'd1);
        bus_start();
        send_byte({TADDR, 1'b1}, a);
        mon = 1'b0;
        recv_byte(1'b0, v);
        chk("R12 byte before nack", v, 8'h5A);
        oe_seen = 1'b0;
        mon = 1'b1;
        for (int i = 0; i < 9; i++) begin
            hold(); scl_m = 1'b1; hold(); scl_m = 1'b0;
        end
        hold();
        mon = 1'b0;
        bus_stop();
        chk("R12 SDA released after nack", {7'd0, oe_seen}, 8'h00);
    endtask

    task automatic t_restart();
        logic a0, a1, a2, a3;
        logic [7:0] v1, v2;
        bus_start();
        send_byte({TADDR, 1'b0}, a0);
        send_byte(8'h03, a1);
        bus_restart();
        send_byte({TADDR, 1'b1}, a2);
        recv_byte(1'b0, v1);
        bus_stop();
        chk("R13 address matched after restart", {7'd0, a2}, 8'h01);
        chk("R13 selector from before restart", v1, 8'hFF);
        bus_start();
        send_byte({TADDR, 1'b1}, a2);
        recv_byte(1'b0, v1);
        bus_restart();
        send_byte({TADDR, 1'b1}, a3);
        recv_byte(1'b0, v2);
        bus_stop();
        chk("R13 selector kept across restart", v2, 8'hFF);
    endtask

    task automatic t_stop();
        logic a;
        logic [7:0] v;
        set_ptr(2'd1);
        scl_m = 1'b0; hold();
        oe_seen = 1'b0;
        mon = 1'b1;
        send_byte({TADDR, 1'b0}, a);
        send_byte(8'h02, a);
        mon = 1'b0;
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        chk("R14 no drive without START", {7'd0, oe_seen}, 8'h00);
        rd_cur(v);
        chk("R14 selector untouched after stop", v, 8'h5A);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_reset();
        t_address();
        t_write_latch();
        t_multi_write();
        t_direction();
        t_invert();
        t_persist();
        t_pin_write();
        t_multi_read();
        t_interrupt();
        t_nack();
        t_restart();
        t_stop();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule